// File: doc/BRIEF.md
# Pipelined Three-Tap Window Summer with Parallel Lanes

This block is a streaming datapath. It turns a stream of small unsigned elements into the sum of every three consecutive elements. On each clock it accepts one input group: a wide word that packs `LANES + 2` consecutive elements. From that group it produces `LANES` results, one per lane. Lane `j` adds elements `j`, `j+1` and `j+2`.

Neighbouring lanes share two of their three operands. A group therefore needs only two more elements than there are lanes. For example, 8-bit elements in a 64-bit word give six lanes, and in a 128-bit word they give fourteen.

Each lane works in two registered adder levels:
- The first level adds the lower two elements of the window.
- The third element waits in a delay register, so that it meets its own partial sum in the second level.

A new group may enter on every cycle. Each result leaves two clock edges after its group entered.

A valid flag travels with the data. A per-lane mask also travels with it, so that a short final group can mark which lanes carry real results.

Top module: `win3_sum_pipe`

## Requirements
- R1: For an accepted group, lane `j` result equals the unsigned sum of elements `j`, `j+1` and `j+2` of that group. Element `k` sits in `in_data[k*ELEM_W +: ELEM_W]` and lane `j` result sits in `out_sum[j*(ELEM_W+2) +: ELEM_W+2]`.
- R2: A group sampled at clock edge `n` is presented on the outputs right after edge `n+1` (latency of two registered levels).
- R3: Each result is `ELEM_W+2` bits wide, so three maximum-value elements sum without overflow.
- R4: `out_valid` equals `in_valid` delayed by two edges, and it stays low after reset until the first accepted group reaches the output.
- R5: When `out_valid` is high, `out_lane_mask` equals the `in_lane_mask` sampled with that group, and a 1 bit marks a lane holding a real result.
- R6: Groups accepted on consecutive cycles each produce their own results on consecutive cycles, with no operand taken from a neighbouring group.
- R7: Synchronous active-high `rst` clears every pipeline register: on the edge after `rst` is sampled high, `out_valid` is 0 and all results and mask bits are 0.
- R8: A lane whose mask bit is 0, and every lane while `out_valid` is 0, outputs a result of zero. While `out_valid` is 0, `out_lane_mask` is also zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input group is present this cycle |
| in_lane_mask | input | LANES | Lanes of this group that hold real work |
| in_data | input | (LANES+2)*ELEM_W | Packed consecutive elements, element 0 in the low bits |
| out_valid | output | 1 | Result group is present |
| out_lane_mask | output | LANES | Lanes of the result group that hold real results |
| out_sum | output | LANES*(ELEM_W+2) | Packed lane sums, lane 0 in the low bits |

## Verification
The hardest case to reach from the ports is a misaligned third operand. It only shows when successive groups differ, and when the element that skips the first adder level is compared against a partial sum from a different group. The bench therefore streams every possible input word of a small 3-lane, 3-bit configuration back to back. Because the word counts up, each group differs from the previous one in its low elements and, regularly, in the upper element as well. After that sweep, bubbles, random partial masks and a reset in the middle of a full pipeline are mixed into the stream.

// File: rtl/win3_sum_pkg.sv
package win3_sum_pkg;

    // Default configuration: byte elements fed from a 64-bit word.
    localparam int DEF_ELEM_W = 8;
    localparam int DEF_LANES  = 6;

    // Number of registered levels between input and output.
    localparam int PIPE_DEPTH = 2;

    // Growth of two bits covers the sum of three operands.
    function automatic int sum_width(input int elem_w);
        return elem_w + 2;
    endfunction

    // Overlapping windows: the first lane needs three elements, each
    // additional lane one more.
    function automatic int group_width(input int elem_w, input int lanes);
        return (lanes + 2) * elem_w;
    endfunction

    // Lanes that fit in a given input width for a given element width.
    function automatic int lanes_for_width(input int word_w, input int elem_w);
        return (word_w / elem_w) - 2;
    endfunction

endpackage

// File: rtl/win3_lane.sv
module win3_lane
    import win3_sum_pkg::*;
#(
    parameter int ELEM_W = DEF_ELEM_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          lane_ok,
    input  logic [ELEM_W-1:0]             opnd_lo,
    input  logic [ELEM_W-1:0]             opnd_mid,
    input  logic [ELEM_W-1:0]             opnd_hi,
    output logic [sum_width(ELEM_W)-1:0]  lane_sum
);
    localparam int PART_W = ELEM_W + 1;
    localparam int SUM_W  = sum_width(ELEM_W);

    // First adder level
    logic [PART_W-1:0] part_q;
    logic [ELEM_W-1:0] hi_dly_q;   // delay register: keeps third operand aligned
    logic              ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            part_q   <= '0;
            hi_dly_q <= '0;
            ok_q     <= 1'b0;
        end else begin
            part_q   <= PART_W'(opnd_lo) + PART_W'(opnd_mid);
            hi_dly_q <= opnd_hi;
            ok_q     <= lane_ok;
        end
    end

    // Second adder level
    always_ff @(posedge clk) begin
        if (rst) begin
            lane_sum <= '0;
        end else if (ok_q) begin
            lane_sum <= SUM_W'(part_q) + SUM_W'(hi_dly_q);
        end else begin
            lane_sum <= '0;
        end
    end

endmodule

// File: rtl/win3_tag_pipe.sv
module win3_tag_pipe
    import win3_sum_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int DEPTH = PIPE_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tag_valid_in,
    input  logic [LANES-1:0] tag_mask_in,
    output logic             tag_valid_out,
    output logic [LANES-1:0] tag_mask_out
);
    typedef struct packed {
        logic             vld;
        logic [LANES-1:0] msk;
    } tag_t;

    tag_t stage_q [DEPTH];
    tag_t head;

    always_comb begin
        head.vld = tag_valid_in;
        head.msk = tag_valid_in ? tag_mask_in : '0;
    end

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= head;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign tag_valid_out = stage_q[DEPTH-1].vld;
    assign tag_mask_out  = stage_q[DEPTH-1].msk;

endmodule

// File: rtl/win3_sum_pipe.sv
module win3_sum_pipe
    import win3_sum_pkg::*;
#(
    parameter int ELEM_W = DEF_ELEM_W,
    parameter int LANES  = DEF_LANES
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 in_valid,
    input  logic [LANES-1:0]                     in_lane_mask,
    input  logic [(LANES+2)*ELEM_W-1:0]          in_data,
    output logic                                 out_valid,
    output logic [LANES-1:0]                     out_lane_mask,
    output logic [LANES*(ELEM_W+2)-1:0]          out_sum
);
    localparam int SUM_W = sum_width(ELEM_W);
    localparam int IN_W  = group_width(ELEM_W, LANES);
    localparam int NELEM = LANES + 2;

    logic [ELEM_W-1:0] elem [NELEM];

    for (genvar k = 0; k < NELEM; k++) begin : g_unpack
        assign elem[k] = in_data[k*ELEM_W +: ELEM_W];
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        win3_lane #(.ELEM_W(ELEM_W)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .lane_ok  (in_valid & in_lane_mask[j]),
            .opnd_lo  (elem[j]),
            .opnd_mid (elem[j+1]),
            .opnd_hi  (elem[j+2]),
            .lane_sum (out_sum[j*SUM_W +: SUM_W])
        );
    end

    win3_tag_pipe #(.LANES(LANES), .DEPTH(PIPE_DEPTH)) u_tags (
        .clk           (clk),
        .rst           (rst),
        .tag_valid_in  (in_valid),
        .tag_mask_in   (in_lane_mask),
        .tag_valid_out (out_valid),
        .tag_mask_out  (out_lane_mask)
    );

endmodule

// File: rtl/win3_sum_pipe_chk.sv
module win3_sum_pipe_chk #(
    parameter int ELEM_W = 8,
    parameter int LANES  = 6
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         in_valid,
    input logic [LANES-1:0]             in_lane_mask,
    input logic [(LANES+2)*ELEM_W-1:0]  in_data,
    input logic                         out_valid,
    input logic [LANES-1:0]             out_lane_mask,
    input logic [LANES*(ELEM_W+2)-1:0]  out_sum
);
    localparam int SW = ELEM_W + 2;

    // Edges since reset release, saturating at two.
    logic [1:0] warm_cnt;
    always_ff @(posedge clk) begin
        if (rst)                  warm_cnt <= 2'd0;
        else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
    end
    wire warm = (warm_cnt == 2'd2);

    // R7: reset clears the output side
    a_r7_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_lane_mask == '0 && out_sum == '0));

    // R2, R4: valid delayed by two edges
    a_r4_valid_delay: assert property (@(posedge clk) disable iff (rst)
        warm |-> (out_valid == $past(in_valid, 2)));

    // R5: mask travels with its group
    a_r5_mask_follows: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid) |-> (out_lane_mask == $past(in_lane_mask, 2)));

    // R8: idle output is zero
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_lane_mask == '0 && out_sum == '0));

    for (genvar j = 0; j < LANES; j++) begin : g_lane_chk
        // R1, R6: lane sum built from operands of one group
        a_r1_lane_sum: assert property (@(posedge clk) disable iff (rst)
            (warm && out_valid && out_lane_mask[j]) |->
            (out_sum[j*SW +: SW] == $past(SW'(in_data[j*ELEM_W +: ELEM_W])
                                        + SW'(in_data[(j+1)*ELEM_W +: ELEM_W])
                                        + SW'(in_data[(j+2)*ELEM_W +: ELEM_W]), 2)));

        // R8: masked-off lane outputs zero
        a_r8_lane_off_zero: assert property (@(posedge clk) disable iff (rst)
            !out_lane_mask[j] |-> (out_sum[j*SW +: SW] == '0));
    end

endmodule

bind win3_sum_pipe win3_sum_pipe_chk #(.ELEM_W(ELEM_W), .LANES(LANES)) u_win3_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_lane_mask  (in_lane_mask),
    .in_data       (in_data),
    .out_valid     (out_valid),
    .out_lane_mask (out_lane_mask),
    .out_sum       (out_sum)
);

// File: tb/test_win3_sum_pipe.sv
`timescale 1ns/1ps
module test_win3_sum_pipe;
    localparam int W    = 3;
    localparam int L    = 3;
    localparam int SW   = W + 2;
    localparam int IN_W = (L + 2) * W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [L-1:0]      in_lane_mask = '0;
    logic [IN_W-1:0]   in_data = '0;
    logic              out_valid;
    logic [L-1:0]      out_lane_mask;
    logic [L*SW-1:0]   out_sum;

    always #2 clk = ~clk;   // 250 MHz

    win3_sum_pipe #(.ELEM_W(W), .LANES(L)) i_win3_sum_pipe (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_lane_mask  (in_lane_mask),
        .in_data       (in_data),
        .out_valid     (out_valid),
        .out_lane_mask (out_lane_mask),
        .out_sum       (out_sum)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit summary_done = 0;

    // Model of the group two steps back and one step back.
    logic            p1_v, p2_v;
    logic [L-1:0]    p1_m, p2_m;
    logic [IN_W-1:0] p1_d, p2_d;

    function automatic int elem_of(input logic [IN_W-1:0] d, input int k);
        return int'(d[k*W +: W]);
    endfunction

    task automatic check_outputs(input string tag);
        int exp_s;
        n_chk++;
        if (out_valid !== p2_v) begin
            n_fail++;
            $display("FAIL R2/R4 %s: out_valid=%0b expected %0b", tag, out_valid, p2_v);
        end
        n_chk++;
        if (out_lane_mask !== (p2_v ? p2_m : '0)) begin
            n_fail++;
            $display("FAIL R5 %s: out_lane_mask=%b expected %b", tag, out_lane_mask,
                     p2_v ? p2_m : '0);
        end
        for (int j = 0; j < L; j++) begin
            exp_s = (p2_v && p2_m[j]) ? elem_of(p2_d, j) + elem_of(p2_d, j+1) + elem_of(p2_d, j+2) : 0;
            n_chk++;
            if (int'(out_sum[j*SW +: SW]) != exp_s) begin
                n_fail++;
                $display("FAIL %s %s lane %0d: sum=%0d expected %0d",
                         (p2_v && p2_m[j]) ? "R1/R6" : "R8", tag, j,
                         out_sum[j*SW +: SW], exp_s);
            end
        end
    endtask

    // Called at a negative edge: check, then drive the next group.
    task automatic step(input logic v, input logic [L-1:0] m, input logic [IN_W-1:0] d,
                        input string tag);
        check_outputs(tag);
        in_valid     = v;
        in_lane_mask = m;
        in_data      = d;
        p2_v = p1_v; p2_m = p1_m; p2_d = p1_d;
        p1_v = v;    p1_m = m;    p1_d = d;
        @(negedge clk);
    endtask

    task automatic clear_model();
        p1_v = 0; p2_v = 0; p1_m = '0; p2_m = '0; p1_d = '0; p2_d = '0;
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (160000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        finish_run();
    end

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        // R7: reset state
        check_outputs("R7 reset state");
        rst = 1'b0;
        @(negedge clk);

        // R1, R2, R6: exhaustive back-to-back sweep of every input word
        for (int k = 0; k < (1 << IN_W); k++)
            step(1'b1, '1, IN_W'(k), "sweep");

        // R3: all elements at maximum
        step(1'b1, '1, '1, "R3 max");
        step(1'b1, '1, '1, "R3 max");
        step(1'b0, '0, '0, "drain");
        step(1'b0, '0, '0, "drain");
        check_outputs("R3 drained");

        // R4, R5, R8: bubbles, partial masks, masked-off lanes with live data
        for (int k = 0; k < 3000; k++)
            step(1'($urandom_range(0, 2) != 0), L'($urandom), IN_W'($urandom), "mixed");

        // R5: final partial group after a full run
        step(1'b1, '1, IN_W'($urandom), "pre-tail");
        step(1'b1, L'(1), '1, "R5 tail");
        step(1'b0, '1, '1, "R8 idle with mask");
        step(1'b0, '0, '0, "drain");
        step(1'b0, '0, '0, "drain");

        // R7: reset with the pipeline full
        step(1'b1, '1, '1, "prefill");
        step(1'b1, '1, '1, "prefill");
        rst = 1'b1;
        @(negedge clk);
        clear_model();
        check_outputs("R7 mid-stream reset");
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check_outputs("R7 after release");
        for (int k = 0; k < 8; k++)
            step(1'b1, '1, IN_W'(k * 977), "R4 refill");
        step(1'b0, '0, '0, "drain");
        step(1'b0, '0, '0, "drain");
        check_outputs("end");

        finish_run();
    end

endmodule